// File: doc/BRIEF.md
# Cable Presence Monitor with Automatic Output Power Gating

This controller watches the load-sense indications of the first two analog output channels of a video output stage. At each frame-start pulse it decides which channels are being watched, records whether a load was found on each watched channel, and publishes the result as two status bits. Between frame-start pulses the status does not change.

When automatic power gating is switched on, together with detection, the same check also decides which of the three output channels are switched off for the frame that follows. The mapping depends on the output arrangement. In the composite/S-video arrangement, channel 1 is gated by itself and channel 2 carries channel 3 with it. In the component/RGB arrangement, channel 1 alone decides the state of all three channels.

A channel is judged only on its host power bit, never on the gated enable. A channel that was switched off for missing a load is therefore still checked at the next frame start, and comes back on as soon as a load appears.

Top module: `cdpd_top`

## Requirements
- R1: After reset, both status bits read 1 and no power-down request is active, so `ch_pwr_en` equals `host_pwr`.
- R2: Status bits change only on a clock edge where `frame_start` is 1, and hold their value at every other edge.
- R3: Status bit 0 belongs to channel 1 and bit 1 to channel 2. A watched channel with `sense_present` bit = 1 (load found) gets status 0, and one with `sense_present` bit = 0 gets status 1.
- R4: With `cfg_mode` = 0 (composite/S-video), both channels are watched. With `cfg_mode` = 1 (component/RGB), only channel 1 is watched and status bit 1 holds its value.
- R5: A channel is watched only when `full_drive` is 1 and its `host_pwr` bit is 1. An unwatched channel's status bit holds its value.
- R6: With `detect_en` = 0, no status bit changes and no channel is gated off, whatever `autopd_en` is.
- R7: In composite/S-video mode with gating active, a missing load on watched channel 1 turns off channel 1 only. A missing load on watched channel 2 turns off channels 2 and 3.
- R8: In component/RGB mode with gating active, a missing load on watched channel 1 turns off all three channels. The channel 2 sense flag has no effect.
- R9: While `autopd_en` or `detect_en` is 0, `ch_pwr_en` equals `host_pwr` in the same cycle.
- R10: The gating decision made at a frame start holds until the next frame start, whatever the sense flags do in between.
- R11: A channel that was gated off is checked again at the next frame start. If a load is found, the channel is powered again from that frame on.
- R12: Each `ch_pwr_en` bit is its `host_pwr` bit AND NOT the stored power-down request for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| sense_present | input | 2 | Load-sense flags for channels 1 and 2 (1 = load found) |
| cfg_mode | input | 1 | Output arrangement: 0 composite/S-video, 1 component/RGB |
| full_drive | input | 1 | 1 when the outputs run at full drive strength |
| host_pwr | input | 3 | Host power-up bits for channels 1 to 3 |
| detect_en | input | 1 | Enables cable detection |
| autopd_en | input | 1 | Enables automatic power gating (needs detect_en) |
| cable_stat | output | 2 | Detection status: 0 = cable found, 1 = none |
| ch_pwr_en | output | 3 | Final power enables for channels 1 to 3 |

## Verification
The main check runs every combination of arrangement, drive strength, host power bits, both enables and the two sense flags, a frame-start pulse at a time. Status history is carried from one combination to the next, so an unwatched bit that wrongly updates or wrongly resets shows up as a mismatch. After each pulse the sense flags are inverted mid-frame, which separates logic that latches the decision from logic that follows the live flags. Directed frames then gate every channel off and restore it with a found load, which exposes eligibility tied to the gated enable instead of the host bit. The gating enable is also dropped mid-frame, which tells an immediate bypass from one that waits for the next frame.

// File: rtl/cdpd_pkg.sv
package cdpd_pkg;
    localparam int N_SENSE = 2;
    localparam int N_CH    = 3;

    typedef enum logic {
        CFG_COMPOSITE = 1'b0,
        CFG_COMPONENT = 1'b1
    } out_cfg_t;

    typedef struct packed {
        logic [N_SENSE-1:0] watched;
        logic [N_SENSE-1:0] absent;
    } sense_res_t;

    // Map per-sense "no load" flags to per-channel power-down requests.
    function automatic logic [N_CH-1:0] pd_map(out_cfg_t cfg, logic [N_SENSE-1:0] absent);
        logic [N_CH-1:0] r;
        if (cfg == CFG_COMPONENT) begin
            r = {N_CH{absent[0]}};
        end else begin
            r = '0;
            r[0] = absent[0];
            for (int k = 1; k < N_CH; k++) r[k] = absent[1];
        end
        return r;
    endfunction
endpackage

// File: rtl/cdpd_monitor.sv
module cdpd_monitor
    import cdpd_pkg::*;
#(
    parameter int NS = N_SENSE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic          detect_en,
    input  logic          full_drive,
    input  out_cfg_t      cfg,
    input  logic [NS-1:0] host_pwr,
    input  logic [NS-1:0] sense_present,
    output logic [NS-1:0] cable_stat,
    output sense_res_t    res
);
    // Eligibility uses host bits, not gated enables, so gated channels are re-checked.
    for (genvar i = 0; i < NS; i++) begin : g_ch
        logic cfg_ok;
        if (i == 0) begin : g_first
            assign cfg_ok = 1'b1;
        end else begin : g_rest
            assign cfg_ok = (cfg == CFG_COMPOSITE);
        end
        assign res.watched[i] = detect_en & full_drive & host_pwr[i] & cfg_ok;
        assign res.absent[i]  = res.watched[i] & ~sense_present[i];

        logic stat_q;
        always_ff @(posedge clk) begin
            if (rst)
                stat_q <= 1'b1;
            else if (frame_start && res.watched[i])
                stat_q <= ~sense_present[i];
        end
        assign cable_stat[i] = stat_q;
    end

    assert_stat_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cable_stat));
    assert_comp_bit1_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_start && cfg == CFG_COMPONENT) |=> $stable(cable_stat[NS-1]));
    assert_nodetect_R6: assert property (@(posedge clk) disable iff (rst)
        !detect_en |=> $stable(cable_stat));
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> cable_stat == '1);
endmodule

// File: rtl/cdpd_gate.sv
module cdpd_gate
    import cdpd_pkg::*;
#(
    parameter int NC = N_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic          auto_active,
    input  logic [NC-1:0] req_next,
    input  logic [NC-1:0] host_pwr,
    output logic [NC-1:0] ch_pwr_en
);
    logic [NC-1:0] pd_q;

    always_ff @(posedge clk) begin
        if (rst)
            pd_q <= '0;
        else if (frame_start)
            pd_q <= auto_active ? req_next : '0;
    end

    assign ch_pwr_en = host_pwr & ~(pd_q & {NC{auto_active}});

    assert_pd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(pd_q));
    assert_pd_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !auto_active) |=> pd_q == '0);
endmodule

// File: rtl/cdpd_top.sv
module cdpd_top
    import cdpd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic [N_SENSE-1:0] sense_present,
    input  logic               cfg_mode,
    input  logic               full_drive,
    input  logic [N_CH-1:0]    host_pwr,
    input  logic               detect_en,
    input  logic               autopd_en,
    output logic [N_SENSE-1:0] cable_stat,
    output logic [N_CH-1:0]    ch_pwr_en
);
    out_cfg_t   cfg;
    sense_res_t res;
    logic [N_CH-1:0] req_next;
    logic auto_active;

    assign cfg         = out_cfg_t'(cfg_mode);
    assign auto_active = autopd_en & detect_en;
    assign req_next    = pd_map(cfg, res.absent);

    cdpd_monitor #(.NS(N_SENSE)) u_mon (
        .clk           (clk),
        .rst           (rst),
        .frame_start   (frame_start),
        .detect_en     (detect_en),
        .full_drive    (full_drive),
        .cfg           (cfg),
        .host_pwr      (host_pwr[N_SENSE-1:0]),
        .sense_present (sense_present),
        .cable_stat    (cable_stat),
        .res           (res)
    );

    cdpd_gate #(.NC(N_CH)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .auto_active (auto_active),
        .req_next    (req_next),
        .host_pwr    (host_pwr),
        .ch_pwr_en   (ch_pwr_en)
    );

    assert_bypass_R9: assert property (@(posedge clk) disable iff (rst)
        !(autopd_en && detect_en) |-> ch_pwr_en == host_pwr);
    always_comb begin
        if (!rst) assert_within_host_R12: assert ((ch_pwr_en & ~host_pwr) == '0);
    end
endmodule

// File: tb/cdpd_top_test.sv
`timescale 1ns/1ps
module cdpd_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic [1:0] sense_present = 2'b00;
    logic cfg_mode = 1'b0;
    logic full_drive = 1'b0;
    logic [2:0] host_pwr = 3'b000;
    logic detect_en = 1'b0;
    logic autopd_en = 1'b0;
    logic [1:0] cable_stat;
    logic [2:0] ch_pwr_en;

    int n_run = 0;
    int n_fail = 0;
    logic [1:0] exp_stat;
    logic [2:0] exp_req;

    always #5 clk = ~clk;

    cdpd_top uut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .sense_present(sense_present), .cfg_mode(cfg_mode),
        .full_drive(full_drive), .host_pwr(host_pwr),
        .detect_en(detect_en), .autopd_en(autopd_en),
        .cable_stat(cable_stat), .ch_pwr_en(ch_pwr_en)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent model of one frame-start check.
    task automatic model_frame();
        logic m1, m2, nc1, nc2;
        m1 = detect_en & full_drive & host_pwr[0];
        m2 = detect_en & full_drive & host_pwr[1] & ~cfg_mode;
        if (m1) exp_stat[0] = ~sense_present[0];
        if (m2) exp_stat[1] = ~sense_present[1];
        nc1 = m1 & ~sense_present[0];
        nc2 = m2 & ~sense_present[1];
        if (autopd_en & detect_en)
            exp_req = cfg_mode ? {3{nc1}} : {nc2, nc2, nc1};
        else
            exp_req = 3'b000;
    endtask

    function automatic logic [2:0] exp_en();
        return host_pwr & ~(exp_req & {3{autopd_en & detect_en}});
    endfunction

    task automatic pulse();
        @(negedge clk);
        frame_start = 1'b1;
        model_frame();
        @(negedge clk);
        frame_start = 1'b0;
        #1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        host_pwr = 3'b111;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        exp_stat = 2'b11;
        exp_req  = 3'b000;
        chk("R1 status", {2'b0, cable_stat}, 4'b0011);
        chk("R1 enables", {1'b0, ch_pwr_en}, 4'b0111);

        for (int c = 0; c < 512; c++) begin
            @(negedge clk);
            sense_present = c[1:0];
            autopd_en     = c[2];
            detect_en     = c[3];
            host_pwr      = c[6:4];
            full_drive    = c[7];
            cfg_mode      = c[8];
            pulse();
            chk("R3 R4 R5 R6 status", {2'b0, cable_stat}, {2'b0, exp_stat});
            chk("R7 R8 R12 enables", {1'b0, ch_pwr_en}, {1'b0, exp_en()});
            sense_present = ~sense_present;
            @(negedge clk);
            @(negedge clk);
            #1;
            chk("R2 hold status", {2'b0, cable_stat}, {2'b0, exp_stat});
            chk("R10 hold enables", {1'b0, ch_pwr_en}, {1'b0, exp_en()});
        end

        // R11: gate everything off in component mode, then recover.
        @(negedge clk);
        cfg_mode = 1'b1; full_drive = 1'b1; host_pwr = 3'b111;
        detect_en = 1'b1; autopd_en = 1'b1; sense_present = 2'b00;
        pulse();
        chk("R8 all off", {1'b0, ch_pwr_en}, 4'b0000);
        sense_present = 2'b01;
        pulse();
        chk("R11 recovered enables", {1'b0, ch_pwr_en}, 4'b0111);
        chk("R11 status", {2'b0, cable_stat}, {2'b0, exp_stat});

        // R9: dropping the gating enable mid-frame bypasses at once.
        sense_present = 2'b00;
        pulse();
        chk("R8 off again", {1'b0, ch_pwr_en}, 4'b0000);
        @(negedge clk);
        autopd_en = 1'b0;
        #1;
        chk("R9 bypass", {1'b0, ch_pwr_en}, 4'b0111);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule